// File: doc/BRIEF.md
# Error Response Capture Queue

This block sits on the receive side of a memory link and sorts incoming response packets. A packet whose command code marks it as a dedicated error response is taken out of the stream. Its 7-bit error status and the 3-bit cube number held in its tag are stored in a 16-entry first-in first-out store. Every other response (read, write, mode or any other code) goes through unchanged to the data-path response port. That port raises an error flag whenever the packet's error status is non-zero.

Software drains the store through a single 32-bit readout location. Each read of that location returns the oldest entry and removes it. A valid bit tells software whether the returned fields mean anything. Three more locations hold the interrupt status, the per-source enables and a global enable. Together they drive one interrupt line. One interrupt source is "entries waiting". The other is a sticky flag that records that an error response was dropped because the store was full.

Both packet interfaces use valid/ready. On the input, a transfer happens on a clock edge where `in_valid` and `in_ready` are both high. An error response is always accepted at once, even when the store is full. Any other response is accepted only when `dp_ready` is high, so data-path back-pressure passes straight through to the input. The sender must hold its packet stable until it is accepted.

Top module: `err_rsp_capture`

## Requirements
- R1: A packet with command code 3 (error response) is never presented on `dp_valid`, and `in_ready` is high while it is offered, whatever `dp_ready` is.
- R2: A packet with any other command code (0 read, 1 write, 2 mode, 4..7 other) appears on the data-path port in the same cycle with command, tag and status unchanged. `dp_err` is high exactly when the status is non-zero, and `in_ready` equals `dp_ready`.
- R3: The readout word (address 0) carries the error status in bits 6:0, the cube number in bits 10:8 and the valid bit in bit 16. All other bits are zero. The cube number is the top three bits of the 9-bit tag, tag[8:6].
- R4: A read of address 0 returns its data on `csr_rdata` one cycle after the request and removes the returned entry, so successive reads return entries in arrival order.
- R5: A read of address 0 with the store empty returns all zeros and changes no state.
- R6: The store holds 16 entries. An error response arriving while it is full (and no read is removing an entry in the same cycle) is discarded, and the stored entries are unchanged. It also sets the sticky overflow flag, bit 1 of the status word at address 1.
- R7: A read of address 0 and an accepted error response in the same cycle are both honoured. The read returns the entry that was oldest before that cycle, which is all zeros if the store was empty.
- R8: Status bit 0 reads 1 exactly when the store is non-empty and ignores writes. Writing 1 to bit 1 of address 1 clears the overflow flag. Writing 0 to it leaves the flag alone.
- R9: `irq` is high exactly when the global enable (address 3, bit 0) is set and some status bit is set together with its enable bit (address 2, bits 1:0).
- R10: After reset, all four locations read zero and `irq` is low.
- R11: Addresses 2 and 3 read back the last value written to their defined bits, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Response packet offered |
| in_ready | output | 1 | Response packet accepted this cycle |
| in_cmd | input | 3 | Response command code |
| in_tag | input | 9 | Response tag; top three bits are the cube number |
| in_errstat | input | 7 | Response error status |
| dp_valid | output | 1 | Data-path response offered |
| dp_ready | input | 1 | Data-path consumer can take a response |
| dp_cmd | output | 3 | Forwarded command code |
| dp_tag | output | 9 | Forwarded tag |
| dp_errstat | output | 7 | Forwarded error status |
| dp_err | output | 1 | Forwarded response carries a non-zero error status |
| csr_sel | input | 1 | Register access this cycle |
| csr_wr | input | 1 | Access is a write (else a read) |
| csr_addr | input | 2 | Word address: 0 readout, 1 status, 2 enable, 3 global enable |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt request |

## Verification
A pointer or occupancy count that slips shows up at the ports on the next readout. That read returns a wrong, repeated or skipped entry, or the valid bit reads zero while entries are still pending. So the bench checks each popped word against a scoreboard that holds the entries in arrival order. An overflow boundary that is off by one is caught when the seventeenth entry is pushed: either the flag is missing or a sixteenth entry that should be there is absent on drain. A wrong classification is caught in the same cycle, through `dp_valid`, `in_ready` and the monitor of the data-path stream.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int CUBE_W = 3;
  localparam int ES_W   = 7;

  typedef enum logic [2:0] {
    RSP_READ  = 3'd0,
    RSP_WRITE = 3'd1,
    RSP_MODE  = 3'd2,
    RSP_ERROR = 3'd3
  } rsp_cmd_e;

  typedef struct packed {
    logic [CUBE_W-1:0] cube;
    logic [ES_W-1:0]   status;
  } errq_entry_t;

  localparam logic [1:0] A_READOUT = 2'd0;
  localparam logic [1:0] A_STATUS  = 2'd1;
  localparam logic [1:0] A_ENABLE  = 2'd2;
  localparam logic [1:0] A_GLOBAL  = 2'd3;
endpackage

// File: rtl/errq_classify.sv
module errq_classify
  import errq_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_cmd,
  input  logic [TAG_W-1:0]    in_tag,
  input  logic [ES_W-1:0]     in_errstat,
  output logic                in_ready,
  output logic                dp_valid,
  input  logic                dp_ready,
  output logic                dp_err,
  output logic                push_valid,
  output errq_entry_t         push_entry
);
  logic is_err_rsp;

  always_comb begin
    is_err_rsp        = (in_cmd == RSP_ERROR);
    dp_valid          = in_valid && !is_err_rsp;
    in_ready          = is_err_rsp ? 1'b1 : dp_ready;
    dp_err            = |in_errstat;
    push_valid        = in_valid && is_err_rsp;
    push_entry.cube   = in_tag[TAG_W-1 -: CUBE_W];
    push_entry.status = in_errstat;
  end

  // R1: a dedicated error response never leaks onto the data path and is never stalled
  assert_err_not_forwarded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cmd == RSP_ERROR) |-> (!dp_valid && in_ready));
endmodule

// File: rtl/errq_fifo.sv
module errq_fifo
  import errq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  errq_entry_t push_data,
  input  logic        pop,
  output errq_entry_t head,
  output logic        empty,
  output logic        drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  errq_entry_t     mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic [CW-1:0]   count;
  logic            full, accept;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty  = (count == '0);
    full   = (count == CW'(DEPTH));
    accept = push && (!full || pop);
    drop   = push && full && !pop;
    head   = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= nxt(wptr);
      if (pop)    rptr <= nxt(rptr);
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: occupancy never exceeds the capacity
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6: a discarded push leaves the store full
  assert_drop_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (count == CW'(DEPTH)));
  // R5: the register side only removes entries that exist
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7: a simultaneous accepted push and pop leave the occupancy unchanged
  assert_push_pop_balance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/errq_csr.sv
module errq_csr
  import errq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_sel,
  input  logic        csr_wr,
  input  logic [1:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  errq_entry_t head,
  input  logic        empty,
  input  logic        drop,
  output logic        pop,
  output logic        irq
);
  logic [1:0]  irq_en;
  logic        glob_en;
  logic        ovf;
  logic [1:0]  status;
  logic        rd, wr_status;
  logic [31:0] rd_mux;

  always_comb begin
    status    = {ovf, !empty};
    rd        = csr_sel && !csr_wr;
    wr_status = csr_sel && csr_wr && (csr_addr == A_STATUS);
    pop       = rd && (csr_addr == A_READOUT) && !empty;
    irq       = glob_en && |(status & irq_en);
    rd_mux    = '0;
    case (csr_addr)
      A_READOUT: if (!empty) begin
        rd_mux[ES_W-1:0] = head.status;
        rd_mux[10:8]     = head.cube;
        rd_mux[16]       = 1'b1;
      end
      A_STATUS: rd_mux[1:0] = status;
      A_ENABLE: rd_mux[1:0] = irq_en;
      default:  rd_mux[0]   = glob_en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= '0;
      glob_en   <= 1'b0;
      ovf       <= 1'b0;
      csr_rdata <= '0;
    end else begin
      csr_rdata <= rd ? rd_mux : '0;
      if (csr_sel && csr_wr && csr_addr == A_ENABLE) irq_en  <= csr_wdata[1:0];
      if (csr_sel && csr_wr && csr_addr == A_GLOBAL) glob_en <= csr_wdata[0];
      if (drop)                                     ovf     <= 1'b1;
      else if (wr_status && csr_wdata[1])           ovf     <= 1'b0;
    end
  end

  // R4: a removal always returns a word with the valid bit on the next cycle
  assert_pop_returns_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> csr_rdata[16]);
  // R6: the overflow flag holds until software clears it
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_status && csr_wdata[1])) |=> ovf);
endmodule

// File: rtl/err_rsp_capture.sv
module err_rsp_capture
  import errq_pkg::*;
#(
  parameter int TAG_W = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_cmd,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [ES_W-1:0]  in_errstat,
  output logic             dp_valid,
  input  logic             dp_ready,
  output logic [2:0]       dp_cmd,
  output logic [TAG_W-1:0] dp_tag,
  output logic [ES_W-1:0]  dp_errstat,
  output logic             dp_err,
  input  logic             csr_sel,
  input  logic             csr_wr,
  input  logic [1:0]       csr_addr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  output logic             irq
);
  logic        push_valid, pop, empty, drop;
  errq_entry_t push_entry, head;

  assign dp_cmd     = in_cmd;
  assign dp_tag     = in_tag;
  assign dp_errstat = in_errstat;

  errq_classify #(.TAG_W(TAG_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd),
    .in_tag(in_tag), .in_errstat(in_errstat), .in_ready(in_ready),
    .dp_valid(dp_valid), .dp_ready(dp_ready), .dp_err(dp_err),
    .push_valid(push_valid), .push_entry(push_entry)
  );

  errq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .push_data(push_entry),
    .pop(pop), .head(head), .empty(empty), .drop(drop)
  );

  errq_csr u_csr (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .head(head), .empty(empty), .drop(drop), .pop(pop), .irq(irq)
  );
endmodule

// File: tb/tb_err_rsp_capture.sv
module tb_err_rsp_capture;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [2:0]  in_cmd = 0;
  logic [8:0]  in_tag = 0;
  logic [6:0]  in_errstat = 0;
  logic        dp_valid, dp_ready = 1, dp_err;
  logic [2:0]  dp_cmd;
  logic [8:0]  dp_tag;
  logic [6:0]  dp_errstat;
  logic        csr_sel = 0, csr_wr = 0;
  logic [1:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [19:0] dp_q[$];
  logic        m_ovf = 0;
  logic [31:0] rd;
  bit          done = 0;

  always #5 clk = ~clk;

  err_rsp_capture dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [8:0] tag, input logic [6:0] es);
    return {15'd0, 1'b1, 5'd0, tag[8:6], 1'b0, es};
  endfunction

  // data-path monitor: pops the scoreboard on every transfer
  always @(posedge clk) begin
    if (rst_n && dp_valid && dp_ready) begin
      if (dp_q.size() == 0) check("R1 unexpected dp transfer", {12'd0, dp_cmd, dp_tag, dp_errstat, dp_err}, 32'hffffffff);
      else check("R2 dp packet", {12'd0, dp_cmd, dp_tag, dp_errstat, dp_err}, {12'd0, dp_q.pop_front()});
    end
  end

  task automatic model_push(input logic [2:0] cmd, input logic [8:0] tag, input logic [6:0] es);
    if (cmd == 3'd3) begin
      if (exp_q.size() < 16) exp_q.push_back(word(tag, es));
      else m_ovf = 1;
    end else dp_q.push_back({cmd, tag, es, es != 0});
  endtask

  task automatic send(input logic [2:0] cmd, input logic [8:0] tag, input logic [6:0] es);
    @(negedge clk);
    in_valid = 1; in_cmd = cmd; in_tag = tag; in_errstat = es;
    model_push(cmd, tag, es);
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); csr_sel = 1; csr_wr = 0; csr_addr = a;
    @(negedge clk); csr_sel = 0; d = csr_rdata;
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csr_sel = 1; csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_sel = 0; csr_wr = 0;
  endtask

  task automatic pop_check(input string req);
    logic [31:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'd0;
    csr_read(2'd0, rd);
    check(req, rd, e);
  endtask

  task automatic status_check(input string req);
    csr_read(2'd1, rd);
    check(req, rd, {30'd0, m_ovf, exp_q.size() != 0});
  endtask

  task automatic read_and_push(input logic [8:0] tag, input logic [6:0] es);
    logic [31:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'd0;
    @(negedge clk);
    csr_sel = 1; csr_wr = 0; csr_addr = 2'd0;
    in_valid = 1; in_cmd = 3'd3; in_tag = tag; in_errstat = es;
    model_push(3'd3, tag, es);
    @(negedge clk);
    csr_sel = 0; in_valid = 0;
    check("R7 read with concurrent push", csr_rdata, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset values
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      csr_read(a[1:0], rd);
      check("R10 register after reset", rd, 32'd0);
    end
    // R5 empty read
    pop_check("R5 empty readout");
    status_check("R5 empty read leaves status");

    // R3 R4 ordering and format
    send(3'd3, 9'h1C5, 7'h7F);
    send(3'd3, 9'h040, 7'h01);
    send(3'd3, 9'h0AA, 7'h2A);
    status_check("R8 pending bit set");
    pop_check("R3 R4 first entry");
    pop_check("R4 second entry");
    pop_check("R4 third entry");
    pop_check("R5 drained readout");
    status_check("R8 pending bit clears");

    // R2 forwarding
    send(3'd0, 9'h123, 7'h00);
    send(3'd1, 9'h0F0, 7'h05);
    send(3'd2, 9'h1FF, 7'h40);
    send(3'd6, 9'h001, 7'h00);
    status_check("R1 forwarded packets not queued");
    // R2 back-pressure
    dp_ready = 0;
    @(negedge clk);
    in_valid = 1; in_cmd = 3'd1; in_tag = 9'h055; in_errstat = 7'h03;
    #1;
    check("R2 stalled in_ready", {31'd0, in_ready}, 32'd0);
    check("R2 stalled dp_valid", {31'd0, dp_valid}, 32'd1);
    @(negedge clk);
    model_push(3'd1, 9'h055, 7'h03);
    dp_ready = 1;
    @(posedge clk); #1 in_valid = 0;
    // R1 error response while data path stalled
    dp_ready = 0;
    @(negedge clk);
    in_valid = 1; in_cmd = 3'd3; in_tag = 9'h0C0; in_errstat = 7'h11;
    model_push(3'd3, 9'h0C0, 7'h11);
    #1;
    check("R1 in_ready despite stall", {31'd0, in_ready}, 32'd1);
    check("R1 no dp_valid", {31'd0, dp_valid}, 32'd0);
    @(negedge clk); in_valid = 0; dp_ready = 1;
    pop_check("R1 error response queued");

    // R6 overflow
    for (int i = 0; i < 17; i++) send(3'd3, 9'(i * 37), 7'(i + 1));
    status_check("R6 overflow flag set");
    csr_write(2'd1, 32'h1);
    status_check("R8 write of bit0 ignored");
    csr_write(2'd1, 32'h2);
    m_ovf = 0;
    status_check("R8 overflow cleared");
    for (int i = 0; i < 16; i++) pop_check("R6 retained entry");
    pop_check("R6 dropped entry absent");

    // R7 simultaneous read and push
    read_and_push(9'h1A0, 7'h0E);
    pop_check("R7 entry pushed during empty read");
    send(3'd3, 9'h080, 7'h21);
    read_and_push(9'h140, 7'h22);
    pop_check("R7 entry pushed during read");
    pop_check("R7 drained");

    // R11 R9 interrupts
    csr_write(2'd2, 32'hFFFF_FFFD);
    csr_read(2'd2, rd); check("R11 enable readback", rd, 32'h1);
    csr_write(2'd3, 32'h0);
    send(3'd3, 9'h100, 7'h33);
    @(negedge clk);
    check("R9 irq gated by global", {31'd0, irq}, 32'd0);
    csr_write(2'd3, 32'hFFFF_FFFF);
    csr_read(2'd3, rd); check("R11 global readback", rd, 32'h1);
    check("R9 irq pending", {31'd0, irq}, 32'd1);
    pop_check("R9 pop entry");
    check("R9 irq drops when empty", {31'd0, irq}, 32'd0);
    csr_write(2'd2, 32'h2);
    for (int i = 0; i < 17; i++) send(3'd3, 9'(i), 7'(i));
    @(negedge clk);
    check("R9 irq from overflow", {31'd0, irq}, 32'd1);
    csr_write(2'd1, 32'h2); m_ovf = 0;
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 16; i++) pop_check("R4 final drain");

    repeat (2) @(negedge clk);
    check("R2 all dp packets seen", dp_q.size(), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule